// File: doc/BRIEF.md
# Wrap-Stamped Descriptor Ring

This block is the producer side of a circular descriptor ring held in on-chip memory, together with a consumer-side scanner that finds fresh entries on its own. Every entry is eight 32-bit words. The producer takes seven payload words over a valid/ready stream. It then writes the eighth word itself, as a stamp that carries the ring identifier and a 4-bit count of the passes it has made around the ring.

The scanner walks the ring in slot order. It reads back only the stamp of the slot under its index and compares the low bit of the pass count against the parity it expects for its own current pass. A match means a new entry. Because the producer and the scanner flip parity at the same slot boundary, the scanner finds the end of fresh data from the entries alone, with no head pointer. When it finds one, it reports the slot and the pass count with a one-cycle pulse. The consumer reads the payload through a peek port and then hands the slot back with a release pulse. The producer stalls when every slot is still held.

After reset, the block sweeps the stamp store to zero, so no stale word can look fresh on the first pass.

Top module: `stamp_ring`

## Requirements
- R1: After reset, `push_ready` stays low and `fresh_valid` stays low for exactly DEPTH cycles while the stamp store is cleared. `push_ready` rises in the cycle after the DEPTH-th rising edge that follows reset release.
- R2: An entry is seven payload beats, stored in arrival order as words 0 to 6 of the slot. `push_ready` is low in the cycle after the seventh beat, while word 7 is written. `peek_data` returns word `peek_word` of slot `peek_slot` one clock after the address is presented.
- R3: Word 7 of every written slot holds the pass count in bits 31:28, the parameter RING_TAG in bits 27:20, and zero in bits 19:0.
- R4: The pass count stamped during the k-th pass over the ring (k = 1, 2, ...) is k modulo 16. Entries of the first pass carry 1, and the count continues from 0 after 15.
- R5: When DEPTH entries are written and not released, `push_ready` stays low with no beat lost. One `slot_release` pulse frees the oldest slot, and `push_ready` returns in the next cycle.
- R6: Fresh entries are reported in slot order 0, 1, ..., DEPTH-1, 0, ..., each exactly once. Each report is a `fresh_valid` pulse one cycle long, carrying `fresh_slot` and the stamped `fresh_loop`.
- R7: The scanner decides freshness only from bit 28 of the stamp, against an expected parity that starts at 1 and inverts each time its index wraps. A slot not yet rewritten in the current pass is never reported.
- R8: While `scan_en` is low, no entry is reported and the scan index holds. Reporting resumes from the same slot when `scan_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Payload beat offered |
| push_word | input | 32 | Payload word |
| push_ready | output | 1 | Beat accepted when high together with push_valid |
| scan_en | input | 1 | Consumer can take a new report |
| fresh_valid | output | 1 | One-cycle pulse: a fresh entry was found |
| fresh_slot | output | $clog2(DEPTH) | Slot of the reported entry |
| fresh_loop | output | 4 | Pass count stamped in that entry |
| slot_release | input | 1 | Pulse: oldest reported slot may be overwritten |
| peek_slot | input | $clog2(DEPTH) | Slot to read |
| peek_word | input | 3 | Word index within the slot |
| peek_data | output | 32 | Read data, one cycle after the address |

## Verification
The bench targets the parity flip at the slot wrap. A scanner that failed to invert its expectation would stall on slot 0 of the second pass, and one that flipped a slot early would report stale entries. The pass count is driven well past 15, so a count that saturates or skips 0 shows up in the scoreboard. The ring is filled to the brim with scanning disabled: an overrun would corrupt payload or stamps, and a leaky `scan_en` gate would produce reports early. The bench also looks at the empty ring straight after the clear sweep, where an uncleared or wrongly cleared store would make stale slots look fresh.

// File: rtl/stamp_ring_pkg.sv
package stamp_ring_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 8;
  localparam int BEAT_W      = $clog2(ENTRY_WORDS);
  localparam int PAY_WORDS   = ENTRY_WORDS - 1;
  localparam int LOOP_W      = 4;
  localparam int TAG_W       = 8;
  localparam int LOOP_LSB    = 28;
  localparam int TAG_LSB     = 20;

  typedef enum logic {WR_SWEEP, WR_FILL} wr_state_e;

  // Build the closing word of an entry: pass count, ring tag, zero elsewhere.
  function automatic logic [WORD_W-1:0] form_stamp(input logic [LOOP_W-1:0] loop,
                                                   input logic [TAG_W-1:0]  tag);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LOOP_LSB +: LOOP_W] = loop;
    w[TAG_LSB  +: TAG_W]  = tag;
    return w;
  endfunction
endpackage

// File: rtl/stamp_ring_ram.sv
// Simple dual-port RAM: one write port, one registered read port.
module stamp_ring_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stamp_ring_writer.sv
// Producer: clears the stamp store, then fills slots and stamps each entry.
module stamp_ring_writer
  import stamp_ring_pkg::*;
#(
  parameter int               DEPTH    = 16,
  parameter logic [TAG_W-1:0] RING_TAG = 8'h5C,
  localparam int              IDX_W    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push_valid,
  input  logic [WORD_W-1:0]       push_word,
  output logic                    push_ready,
  input  logic                    slot_release,
  output logic                    armed,
  output logic [IDX_W:0]          ring_occ,
  output logic                    body_we,
  output logic [IDX_W+BEAT_W-1:0] body_waddr,
  output logic [WORD_W-1:0]       body_wdata,
  output logic                    tag_we,
  output logic [IDX_W-1:0]        tag_waddr,
  output logic [LOOP_W-1:0]       tag_wdata
);
  localparam logic [IDX_W:0]    FULL_OCC = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [BEAT_W-1:0] STAMP_BEAT = BEAT_W'(PAY_WORDS);

  wr_state_e          state_q;
  logic [IDX_W-1:0]   sweep_q;
  logic [IDX_W:0]     head_q, tail_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [LOOP_W-1:0]  loop_q;
  logic [IDX_W-1:0]   slot;
  logic               full, stamp_cyc, take;

  assign slot       = head_q[IDX_W-1:0];
  assign ring_occ   = head_q - tail_q;
  assign full       = (ring_occ == FULL_OCC);
  assign armed      = (state_q == WR_FILL);
  assign stamp_cyc  = armed && (beat_q == STAMP_BEAT);
  assign push_ready = armed && (beat_q != STAMP_BEAT) && ((beat_q != '0) || !full);
  assign take       = push_valid && push_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WR_SWEEP;
      sweep_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      beat_q  <= '0;
      loop_q  <= '0;
    end else begin
      if (state_q == WR_SWEEP) begin
        sweep_q <= sweep_q + 1'b1;
        if (sweep_q == LAST_IDX) state_q <= WR_FILL;
      end
      if (take) begin
        beat_q <= beat_q + 1'b1;
        // a new pass starts with the first beat into slot 0
        if (beat_q == '0 && slot == '0) loop_q <= loop_q + 1'b1;
      end
      if (stamp_cyc) begin
        beat_q <= '0;
        head_q <= head_q + 1'b1;
      end
      if (slot_release && ring_occ != '0) tail_q <= tail_q + 1'b1;
    end
  end

  always_comb begin
    body_we    = take || stamp_cyc;
    body_waddr = {slot, beat_q};
    body_wdata = stamp_cyc ? form_stamp(loop_q, RING_TAG) : push_word;
    tag_we     = (state_q == WR_SWEEP) || stamp_cyc;
    tag_waddr  = (state_q == WR_SWEEP) ? sweep_q : slot;
    tag_wdata  = (state_q == WR_SWEEP) ? '0 : loop_q;
  end
endmodule

// File: rtl/stamp_ring_scanner.sv
// Consumer-side scanner: detects fresh slots from the stamp parity alone.
module stamp_ring_scanner
  import stamp_ring_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              scan_en,
  input  logic [LOOP_W-1:0] tag_rdata,
  output logic [IDX_W-1:0]  tag_raddr,
  output logic              fresh_valid,
  output logic [IDX_W-1:0]  fresh_slot,
  output logic [LOOP_W-1:0] fresh_loop
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic             want_q;
  logic             hit;

  // tag_rdata always belongs to idx_q: the read address follows the next index
  assign hit       = armed && scan_en && (tag_rdata[0] == want_q);
  assign tag_raddr = hit ? idx_q + 1'b1 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      want_q      <= 1'b1;
      fresh_valid <= 1'b0;
      fresh_slot  <= '0;
      fresh_loop  <= '0;
    end else begin
      fresh_valid <= hit;
      if (hit) begin
        idx_q      <= idx_q + 1'b1;
        fresh_slot <= idx_q;
        fresh_loop <= tag_rdata;
        if (idx_q == LAST_IDX) want_q <= ~want_q;
      end
    end
  end
endmodule

// File: rtl/stamp_ring.sv
module stamp_ring
  import stamp_ring_pkg::*;
#(
  parameter int               DEPTH    = 16,
  parameter logic [TAG_W-1:0] RING_TAG = 8'h5C,
  localparam int              IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [31:0]       push_word,
  output logic              push_ready,
  input  logic              scan_en,
  output logic              fresh_valid,
  output logic [IDX_W-1:0]  fresh_slot,
  output logic [3:0]        fresh_loop,
  input  logic              slot_release,
  input  logic [IDX_W-1:0]  peek_slot,
  input  logic [2:0]        peek_word,
  output logic [31:0]       peek_data
);
  logic                    armed;
  logic [IDX_W:0]          ring_occ;
  logic                    body_we, tag_we;
  logic [IDX_W+BEAT_W-1:0] body_waddr;
  logic [WORD_W-1:0]       body_wdata;
  logic [IDX_W-1:0]        tag_waddr, tag_raddr;
  logic [LOOP_W-1:0]       tag_wdata, tag_rdata;

  stamp_ring_writer #(.DEPTH(DEPTH), .RING_TAG(RING_TAG)) u_wr (
    .clk, .rst, .push_valid, .push_word, .push_ready, .slot_release,
    .armed, .ring_occ, .body_we, .body_waddr, .body_wdata,
    .tag_we, .tag_waddr, .tag_wdata
  );

  stamp_ring_ram #(.DATA_W(WORD_W), .ADDR_W(IDX_W + BEAT_W)) u_body (
    .clk, .we(body_we), .waddr(body_waddr), .wdata(body_wdata),
    .raddr({peek_slot, peek_word}), .rdata(peek_data)
  );

  stamp_ring_ram #(.DATA_W(LOOP_W), .ADDR_W(IDX_W)) u_tags (
    .clk, .we(tag_we), .waddr(tag_waddr), .wdata(tag_wdata),
    .raddr(tag_raddr), .rdata(tag_rdata)
  );

  stamp_ring_scanner #(.DEPTH(DEPTH)) u_scan (
    .clk, .rst, .armed, .scan_en, .tag_rdata, .tag_raddr,
    .fresh_valid, .fresh_slot, .fresh_loop
  );
endmodule

// File: rtl/stamp_ring_chk.sv
module stamp_ring_chk
  import stamp_ring_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_ready,
  input logic              scan_en,
  input logic              fresh_valid,
  input logic [IDX_W-1:0]  fresh_slot,
  input logic [3:0]        fresh_loop,
  input logic [IDX_W:0]    ring_occ
);
  localparam logic [IDX_W:0] DEPTH_V = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0]          age_q;
  logic [IDX_W+LOOP_W-1:0] seen_q;
  logic [IDX_W-1:0]        exp_slot;
  logic [LOOP_W-1:0]       exp_loop;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q  <= '0;
      seen_q <= '0;
    end else begin
      if (age_q != DEPTH_V) age_q <= age_q + 1'b1;
      if (fresh_valid) seen_q <= seen_q + 1'b1;
    end
  end

  assign exp_slot = seen_q[IDX_W-1:0];
  assign exp_loop = LOOP_W'(seen_q[IDX_W +: LOOP_W] + 1'b1);

  p_sweep_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (age_q < DEPTH_V) |-> (!push_ready && !fresh_valid));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    ring_occ <= DEPTH_V);

  p_full_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (ring_occ == DEPTH_V) |-> !push_ready);

  p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
    fresh_valid |-> (fresh_slot == exp_slot));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    fresh_valid |=> (!fresh_valid || fresh_slot != $past(fresh_slot)));

  p_loop_count_r4: assert property (@(posedge clk) disable iff (rst)
    fresh_valid |-> (fresh_loop == exp_loop));

  p_scan_gate_r8: assert property (@(posedge clk) disable iff (rst)
    fresh_valid |-> $past(scan_en));
endmodule

bind stamp_ring stamp_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_ready(push_ready), .scan_en(scan_en),
  .fresh_valid(fresh_valid), .fresh_slot(fresh_slot), .fresh_loop(fresh_loop),
  .ring_occ(ring_occ)
);

// File: tb/stamp_ring_test.sv
module stamp_ring_test;
  localparam int         DEPTH = 16;
  localparam int         IDX_W = $clog2(DEPTH);
  localparam logic [7:0] TAG   = 8'hA7;
  localparam int         TOTAL = 22 * DEPTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             push_valid = 1'b0;
  logic [31:0]      push_word = '0;
  logic             push_ready;
  logic             scan_en;
  logic             fresh_valid;
  logic [IDX_W-1:0] fresh_slot;
  logic [3:0]       fresh_loop;
  logic             slot_release = 1'b0;
  logic [IDX_W-1:0] peek_slot = '0;
  logic [2:0]       peek_word = '0;
  logic [31:0]      peek_data;

  logic consume_on = 1'b0;
  logic mon_busy   = 1'b0;
  assign scan_en = consume_on && !mon_busy;

  int checks = 0;
  int errors = 0;
  int got    = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  stamp_ring #(.DEPTH(DEPTH), .RING_TAG(TAG)) uut (
    .clk, .rst, .push_valid, .push_word, .push_ready, .scan_en,
    .fresh_valid, .fresh_slot, .fresh_loop, .slot_release,
    .peek_slot, .peek_word, .peek_data
  );

  function automatic logic [31:0] pay(input int n, input int w);
    return (32'(n) * 32'h9E37_79B1) ^ (32'(w) << 4) ^ 32'h0000_000F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: seven payload beats per entry, expected entry queued on completion.
  task automatic push_entry(input int n);
    for (int w = 0; w < 7; w++) begin
      push_valid = 1'b1;
      push_word  = pay(n, w);
      while (!push_ready) @(negedge clk);
      @(negedge clk);
    end
    push_valid = 1'b0;
    check(push_ready == 1'b0, "R2 stamp cycle stalls input", 32'(push_ready), 32'd0);
    exp_q.push_back(n);
  endtask

  // Monitor: scoreboard of reports, payload and stamp read-back, then release.
  initial begin
    forever begin
      @(negedge clk);
      if (fresh_valid) begin
        int n;
        logic [IDX_W-1:0] s;
        logic [3:0] lp;
        mon_busy = 1'b1;
        s  = fresh_slot;
        lp = fresh_loop;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 stale slot reported", 32'(s), 32'hFFFF_FFFF);
          n = -1;
        end else begin
          n = exp_q.pop_front();
          check(s == IDX_W'(n % DEPTH), "R6 report slot order", 32'(s), 32'(n % DEPTH));
          check(lp == 4'((n / DEPTH + 1) % 16), "R4 pass count", 32'(lp),
                32'((n / DEPTH + 1) % 16));
        end
        for (int w = 0; w < 8; w++) begin
          peek_slot = s;
          peek_word = 3'(w);
          @(negedge clk);
          if (w == 0)
            check(fresh_valid == 1'b0, "R6 one-cycle pulse", 32'(fresh_valid), 32'd0);
          if (n >= 0) begin
            if (w < 7)
              check(peek_data == pay(n, w), "R2 payload word", peek_data, pay(n, w));
            else
              check(peek_data == {lp, TAG, 20'h0}, "R3 stamp word", peek_data,
                    {lp, TAG, 20'h0});
          end
        end
        slot_release = 1'b1;
        @(negedge clk);
        slot_release = 1'b0;
        got++;
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(push_ready == 1'b0, "R1 ready low in reset", 32'(push_ready), 32'd0);
    check(fresh_valid == 1'b0, "R1 no report in reset", 32'(fresh_valid), 32'd0);
    rst = 1'b0;
    k = 0;
    @(negedge clk);
    k = 1;
    while (!push_ready && k < 4 * DEPTH) begin
      check(fresh_valid == 1'b0, "R1 no report while clearing", 32'(fresh_valid), 32'd0);
      @(negedge clk);
      k++;
    end
    check(k == DEPTH, "R1 clear sweep length", 32'(k), 32'(DEPTH));

    // Empty ring: cleared stamps never match the first-pass parity.
    consume_on = 1'b1;
    repeat (30) @(negedge clk);
    check(got == 0, "R7 empty ring reports nothing", 32'(got), 32'd0);
    consume_on = 1'b0;

    // Fill every slot with scanning off.
    for (int n = 0; n < DEPTH; n++) push_entry(n);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(push_ready == 1'b0, "R5 full ring stalls", 32'(push_ready), 32'd0);
    end
    repeat (25) @(negedge clk);
    check(got == 0, "R8 scan disabled holds reports", 32'(got), 32'd0);

    consume_on = 1'b1;
    k = 0;
    while (got < 1 && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(push_ready == 1'b1, "R5 release frees a slot", 32'(push_ready), 32'd1);

    for (int n = DEPTH; n < TOTAL; n++) push_entry(n);

    k = 0;
    while (got < TOTAL && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(got == TOTAL, "R6 every entry reported once", 32'(got), 32'(TOTAL));
    repeat (40) @(negedge clk);
    check(got == TOTAL, "R7 drained ring stays quiet", 32'(got), 32'(TOTAL));
    check(exp_q.size() == 0, "R6 scoreboard empty", 32'(exp_q.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule